// File: doc/BRIEF.md
# Asymmetric Programmable Clock Divider

This block derives a slow interface clock from the system clock. One 32-bit control word carries three 8-bit counts and an enable bit. The counts set how many system cycles the divided clock spends low and how many it spends high. A third count sets when a capture strobe fires after each rising edge. Software picks a division ratio R between 2 and 512 and sets `key = R - 2`. It then writes the low count as `(key + 1) >> 1` and both the high count and the hold count as `key >> 1`. An odd ratio therefore gets the longer phase on the low side.

The divided clock and the strobe are both registered outputs. The block is always at one of two points: stopped, with the output low, or counting from a defined start. A word written while the divider runs is kept aside and used at the next period boundary. The output therefore never shows a shortened pulse.

Top module: `asym_clk_div`

## Requirements
- R1: While reset is high, and on the cycle after it, `div_clk` and `hold_stb` are low. Reset clears the enable, so the divider stays stopped after reset until a write sets the enable bit.
- R2: In `cfg_wdata`, bits 7:0 hold the low count L, bits 15:8 the high count H, bits 23:16 the hold count D, and bit 24 the enable. Bits 31:25 have no effect. A write with bit 24 clear leaves `div_clk` low.
- R3: Suppose a write with the enable set is presented in cycle P while the divider is stopped. Then `div_clk` is low for L+1 cycles starting in cycle P+1, high for H+1 cycles, and this repeats.
- R4: The output period is L+H+2 system cycles. It covers every ratio from 2 (all counts zero) to 512 (L = H = 255).
- R5: With the counts derived from key = R-2 as L = (key+1)>>1 and H = key>>1, an odd R gives a low phase one cycle longer than the high phase. An even R gives equal phases.
- R6: Suppose a write with bit 24 clear is presented in cycle P. Then from cycle P+2 onward, `div_clk` and `hold_stb` stay low.
- R7: Counts written while the divider runs do not alter the period in progress. They take effect from the low phase that follows the next falling edge.
- R8: Number the first high cycle of a period as index 0. `hold_stb` is high for exactly one cycle, at index D+1. D is taken from the counts in force when that rising edge occurs, and a later rising edge restarts the wait.
- R9: Suppose the divider is stopped by clearing the enable and then enabled again by a write in cycle P. It restarts with a full low phase of L+1 cycles beginning in cycle P+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: low, high and hold counts, plus the enable bit |
| div_clk | output | 1 | Divided clock, registered |
| hold_stb | output | 1 | One-cycle capture strobe, registered |

## Verification
The main loop sweeps ratios that are even and odd, small and large. These include the extremes 2 and 512. Even and odd ratios separate an equal phase split from one that puts the extra cycle on the low side. The minimum and maximum ratios show that a counter terminates at zero and at its full count.

Directed patterns cover the remaining behaviour:
- A word with unrelated upper bits set shows that the decode ignores them.
- A word with the enable clear shows that the output stays low.
- A rewrite in the middle of a high phase separates a word applied at once from one deferred to the boundary.
- A hold count longer than the high count places the strobe inside the low phase.
- Stopping while high, then restarting, shows that the counters clear.
- A reset while running shows that the enable is dropped.

// File: rtl/asym_div_pkg.sv
package asym_div_pkg;

  // Default width of each count field in the control word.
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_WORD_W = 32;

  // Level of the divided clock.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } div_phase_e;

endpackage

// File: rtl/cdiv_cfg_regs.sv
// Staged control word plus the shadow copy the counters run from.
module cdiv_cfg_regs #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              boundary,
  output logic              run_en,
  output logic [CNT_W-1:0]  act_low,
  output logic [CNT_W-1:0]  act_high,
  output logic [CNT_W-1:0]  act_hold
);

  localparam int unsigned LO_LSB  = 0;
  localparam int unsigned HI_LSB  = CNT_W;
  localparam int unsigned HD_LSB  = 2 * CNT_W;
  localparam int unsigned EN_BIT  = 3 * CNT_W;
  localparam int unsigned SPARE_W = WORD_W - EN_BIT - 1;

  logic [CNT_W-1:0] stg_low, stg_high, stg_hold;
  logic [CNT_W-1:0] wr_low, wr_high, wr_hold;

  assign wr_low  = cfg_wdata[LO_LSB +: CNT_W];
  assign wr_high = cfg_wdata[HI_LSB +: CNT_W];
  assign wr_hold = cfg_wdata[HD_LSB +: CNT_W];

  // Bits above the enable carry no meaning.
  generate
    if (SPARE_W > 0) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^cfg_wdata[WORD_W-1:EN_BIT+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_low  <= '0;
      stg_high <= '0;
      stg_hold <= '0;
      run_en   <= 1'b0;
      act_low  <= '0;
      act_high <= '0;
      act_hold <= '0;
    end else begin
      if (cfg_we) begin
        stg_low  <= wr_low;
        stg_high <= wr_high;
        stg_hold <= wr_hold;
        run_en   <= cfg_wdata[EN_BIT];
      end
      // While stopped, a write feeds the counters directly so that the
      // first period already uses it; while running, only a boundary does.
      if (cfg_we && !run_en) begin
        act_low  <= wr_low;
        act_high <= wr_high;
        act_hold <= wr_hold;
      end else if (run_en && boundary) begin
        act_low  <= stg_low;
        act_high <= stg_high;
        act_hold <= stg_hold;
      end
    end
  end

endmodule

// File: rtl/cdiv_phase_gen.sv
// Two-phase counter producing the divided clock level.
module cdiv_phase_gen
  import asym_div_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] act_low,
  input  logic [CNT_W-1:0] act_high,
  output div_phase_e       phase,
  output logic             boundary,
  output logic             rise_evt
);

  logic [CNT_W-1:0] cnt;
  logic             low_done, high_done;

  assign low_done  = (cnt == act_low);
  assign high_done = (cnt == act_high);

  // Edge at which the high phase ends: the period boundary.
  assign boundary = run_en && (phase == PH_HIGH) && high_done;
  // Edge at which the output switches high.
  assign rise_evt = run_en && (phase == PH_LOW) && low_done;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      phase <= PH_LOW;
      cnt   <= '0;
    end else if (phase == PH_LOW) begin
      if (low_done) begin
        phase <= PH_HIGH;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (high_done) begin
        phase <= PH_LOW;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cdiv_hold_timer.sv
// Delays each rising edge by a programmed count and emits a one-cycle strobe.
module cdiv_hold_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             rise_evt,
  input  logic [CNT_W-1:0] act_hold,
  output logic             hold_stb
);

  logic             armed;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] tgt;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      armed    <= 1'b0;
      hcnt     <= '0;
      tgt      <= '0;
      hold_stb <= 1'b0;
    end else begin
      hold_stb <= 1'b0;
      if (armed) begin
        if (hcnt == tgt) begin
          hold_stb <= 1'b1;
          armed    <= 1'b0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
      // A fresh rising edge restarts the wait with the current count.
      if (rise_evt) begin
        armed <= 1'b1;
        hcnt  <= '0;
        tgt   <= act_hold;
      end
    end
  end

endmodule

// File: rtl/asym_clk_div.sv
// Programmable divider with separate low, high and hold counts.
module asym_clk_div
  import asym_div_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              div_clk,
  output logic              hold_stb
);

  logic             run_en;
  logic [CNT_W-1:0] act_low, act_high, act_hold;
  logic             boundary, rise_evt;
  div_phase_e       phase;

  cdiv_cfg_regs #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .boundary  (boundary),
    .run_en    (run_en),
    .act_low   (act_low),
    .act_high  (act_high),
    .act_hold  (act_hold)
  );

  cdiv_phase_gen #(
    .CNT_W (CNT_W)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .act_low  (act_low),
    .act_high (act_high),
    .phase    (phase),
    .boundary (boundary),
    .rise_evt (rise_evt)
  );

  cdiv_hold_timer #(
    .CNT_W (CNT_W)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .rise_evt (rise_evt),
    .act_hold (act_hold),
    .hold_stb (hold_stb)
  );

  assign div_clk = (phase == PH_HIGH);

endmodule

// File: rtl/asym_clk_div_chk.sv
// Property checker attached to the divider top.
module asym_clk_div_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic              div_clk,
  input logic              hold_stb,
  input logic [CNT_W-1:0]  act_low,
  input logic [CNT_W-1:0]  act_high
);

  localparam int unsigned EN_BIT = 3 * CNT_W;

  logic             en_q, div_d, lo_ok;
  logic [CNT_W:0]   hi_cnt, lo_cnt;
  logic [CNT_W-1:0] hi_exp, lo_exp;

  generate
    if (WORD_W > EN_BIT + 1) begin : g_top_bits
      logic chk_unused_hi;
      assign chk_unused_hi = ^cfg_wdata[WORD_W-1:EN_BIT+1];
    end
  endgenerate
  logic chk_unused_lo;
  assign chk_unused_lo = ^cfg_wdata[EN_BIT-1:0];

  // Independent tracking of the enable and of each phase length.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      div_d  <= 1'b0;
      lo_ok  <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
      hi_exp <= '0;
      lo_exp <= '0;
    end else begin
      if (cfg_we) en_q <= cfg_wdata[EN_BIT];
      div_d <= div_clk;
      if (div_clk) begin
        if (!div_d) begin
          hi_cnt <= 1;
          hi_exp <= act_high;
        end else begin
          hi_cnt <= hi_cnt + 1'b1;
        end
      end else begin
        if (div_d) begin
          lo_cnt <= 1;
          lo_exp <= act_low;
          lo_ok  <= en_q;
        end else begin
          lo_cnt <= lo_cnt + 1'b1;
        end
      end
      if (!en_q) lo_ok <= 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!div_clk && !hold_stb));

  assert_high_len_R3: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q) && div_d && !div_clk) |-> (hi_cnt == ({1'b0, hi_exp} + 1'b1)));

  assert_low_len_R3: assert property (@(posedge clk) disable iff (rst)
    (lo_ok && en_q && !div_d && div_clk) |-> (lo_cnt == ({1'b0, lo_exp} + 1'b1)));

  assert_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !$past(en_q)) |-> (!div_clk && !hold_stb));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q && div_clk && div_d) |-> $stable(act_high));

endmodule

bind asym_clk_div asym_clk_div_chk #(
  .CNT_W  (CNT_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .div_clk   (div_clk),
  .hold_stb  (hold_stb),
  .act_low   (act_low),
  .act_high  (act_high)
);

// File: tb/asym_clk_div_bench.sv
module asym_clk_div_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int WORD_W     = 32;
  localparam int LIMIT      = 2000;
  localparam int WATCHDOG   = 100000;
  localparam int VEC_N      = 9;

  // {ratio, expected low cycles, expected high cycles}
  localparam logic [29:0] VECS [VEC_N] = '{
    {10'd2,   10'd1,   10'd1},
    {10'd3,   10'd2,   10'd1},
    {10'd4,   10'd2,   10'd2},
    {10'd5,   10'd3,   10'd2},
    {10'd10,  10'd5,   10'd5},
    {10'd17,  10'd9,   10'd8},
    {10'd100, 10'd50,  10'd50},
    {10'd201, 10'd101, 10'd100},
    {10'd512, 10'd256, 10'd256}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [WORD_W-1:0] cfg_wdata = '0;
  logic              div_clk, hold_stb;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asym_clk_div #(
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W)
  ) u_asym_clk_div (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .div_clk   (div_clk),
    .hold_stb  (hold_stb)
  );

  function automatic logic [31:0] make_word(int lo, int hi, int hd, bit en);
    return (32'(en) << 24) | (32'(hd & 255) << 16) | (32'(hi & 255) << 8) | 32'(lo & 255);
  endfunction

  function automatic logic [31:0] ratio_word(int r);
    int key;
    key = r - 2;
    return make_word((key + 1) >> 1, key >> 1, key >> 1, 1'b1);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge in the cycle after
  // the write was sampled.
  task automatic put(logic [31:0] w);
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic measure_period(output int lo, output int hi, output int sx);
    lo = 0;
    while (div_clk == 1'b0 && lo < LIMIT) begin
      lo++;
      @(negedge clk);
    end
    hi = 0;
    sx = -1;
    while (div_clk == 1'b1 && hi < LIMIT) begin
      if (hold_stb && sx < 0) sx = hi;
      hi++;
      @(negedge clk);
    end
    if (hold_stb && sx < 0) sx = hi;
  endtask

  task automatic wait_rise();
    int n;
    n = 0;
    while (!div_clk && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_window(int len, output int highs, output int stbs);
    highs = 0;
    stbs  = 0;
    for (int k = 0; k < len; k++) begin
      if (div_clk) highs++;
      if (hold_stb) stbs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lo, hi, sx, lo2, hi2, sx2, highs, stbs, ratio, el, eh, n, idx, first_idx;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 div_clk in reset", int'(div_clk), 0);
    check("R1 hold_stb in reset", int'(hold_stb), 0);
    rst = 1'b0;
    count_window(10, highs, stbs);
    check("R1 stays stopped after reset", highs + stbs, 0);

    // Main sweep: R3, R4, R5, R8
    for (int i = 0; i < VEC_N; i++) begin
      ratio = int'(VECS[i][29:20]);
      el    = int'(VECS[i][19:10]);
      eh    = int'(VECS[i][9:0]);
      put(32'h0);
      repeat (2) @(negedge clk);
      put(ratio_word(ratio));
      measure_period(lo, hi, sx);
      check($sformatf("R3 first low ratio=%0d", ratio), lo, el);
      check($sformatf("R3 first high ratio=%0d", ratio), hi, eh);
      check($sformatf("R8 strobe index ratio=%0d", ratio), sx, eh);
      measure_period(lo2, hi2, sx2);
      check($sformatf("R4 period ratio=%0d", ratio), lo2 + hi2, ratio);
      check($sformatf("R5 phase split ratio=%0d", ratio), lo2 - hi2, ratio % 2);
    end

    // R2: enable clear keeps output low, upper bits ignored
    put(32'h0);
    repeat (2) @(negedge clk);
    put(make_word(3, 3, 3, 1'b0) | 32'hFE00_0000);
    count_window(20, highs, stbs);
    check("R2 enable clear leaves output low", highs, 0);
    put(make_word(2, 1, 1, 1'b1) | 32'hFE00_0000);
    measure_period(lo, hi, sx);
    check("R2 low count from bits 7:0", lo, 3);
    check("R2 high count from bits 15:8", hi, 2);

    // R6: stop in the middle of a high phase
    put(32'h0);
    repeat (2) @(negedge clk);
    put(ratio_word(10));
    wait_rise();
    @(negedge clk);
    put(32'h0);
    @(negedge clk);
    count_window(30, highs, stbs);
    check("R6 output low after stop", highs, 0);
    check("R6 strobe low after stop", stbs, 0);

    // R7: rewrite during a high phase
    put(32'h0);
    repeat (2) @(negedge clk);
    put(make_word(3, 3, 3, 1'b1));
    wait_rise();
    n = 1;
    put(make_word(1, 6, 6, 1'b1));
    while (div_clk && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
    check("R7 current high keeps old count", n, 4);
    measure_period(lo, hi, sx);
    check("R7 next low uses new count", lo, 2);
    check("R7 next high uses new count", hi, 7);

    // R8: hold count longer than the high phase
    put(32'h0);
    repeat (2) @(negedge clk);
    put(make_word(2, 1, 3, 1'b1));
    wait_rise();
    first_idx = -1;
    stbs = 0;
    for (int k = 0; k < 5; k++) begin
      if (hold_stb) begin
        stbs++;
        if (first_idx < 0) first_idx = k;
      end
      @(negedge clk);
    end
    check("R8 strobe at hold+1", first_idx, 4);
    check("R8 strobe single cycle", stbs, 1);

    // R9: restart after a stop
    put(32'h0);
    repeat (3) @(negedge clk);
    put(make_word(2, 0, 0, 1'b1));
    measure_period(lo, hi, sx);
    check("R9 restart low phase", lo, 3);
    check("R9 restart high phase", hi, 1);

    // R1: reset while running drops the enable
    wait_rise();
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset forces output low", int'(div_clk), 0);
    rst = 1'b0;
    idx = 0;
    count_window(12, highs, stbs);
    check("R1 stopped after mid-run reset", highs + stbs + idx, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule